// File: doc/BRIEF.md
# Asynchronous Real-Time Counter with Match Events

This block is a 16-bit real-time counter that runs from its own slow counter clock, asynchronous to the peripheral clock on which software talks to it. It counts up from zero to a programmable period and then reloads to zero, flagging an overflow, and it separately flags a compare match against a programmable compare value. Both conditions cross into the peripheral domain twice: once as sticky interrupt flags that software clears by writing ones, and once as single-cycle event pulses for other hardware.

Software writes the enable, period, compare and count values through a small write port in the peripheral domain. Each write is carried into the counter domain by a request/acknowledge handshake, and a per-register busy bit stays high until the counter domain has taken the new value. At very short periods the event outputs are deliberately thinned, because the crossing cannot report every tick as a distinct pulse; the interrupt flags still record every occurrence. The block assumes the peripheral clock runs at least four times faster than the counter clock.

Top module: `rtc_async_counter`

## Requirements
- R1: After reset both interrupt flags, both event outputs and all four busy bits are low, and the enable, period, compare and count values are zero.
- R2: While the synchronized enable is set the count advances by one on each counter-clock tick, and on the tick where the count equals the period it reloads to zero instead, so overflows repeat every period+1 ticks; with enable clear the count holds.
- R3: An overflow sets the overflow flag (irq_ovf) one tick after the count equaled the period; the flag stays set until a write to address 4 with data bit 0 set, and writing 1 to the other flag bit leaves it alone.
- R4: A compare match sets irq_cmp one tick after the count equaled the compare value; it is cleared by a write to address 4 with data bit 1 set, and it never sets when the compare value exceeds the period.
- R5: Addresses are 0 = control (data bit 0 is enable), 1 = period, 2 = compare, 3 = count; an accepted write to address a sets busy[a] on the next peripheral cycle and busy[a] stays high until the counter domain has applied the value.
- R6: A write to a register whose busy bit is set is ignored.
- R7: A write to the count register loads the counter, taking priority over counting on that tick.
- R8: Each event pulse (ev_ovf, ev_cmp) lasts exactly one peripheral cycle and is followed on the next cycle by the matching interrupt flag being set.
- R9: With period 0 an event pulse is emitted for every third occurrence, with period 1 for every second, and with period 2 or more for every occurrence; a period write restarts this thinning phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Peripheral clock |
| prst_n | input | 1 | Active-low asynchronous reset, peripheral domain |
| cclk | input | 1 | Counter clock, asynchronous to pclk |
| crst_n | input | 1 | Active-low asynchronous reset, counter domain |
| wr_en | input | 1 | Write strobe, one pclk cycle per write |
| wr_addr | input | 3 | Register address (0 ctrl, 1 period, 2 compare, 3 count, 4 flag clear) |
| wr_data | input | 16 | Write data |
| busy | output | 4 | Per-register transfer-in-progress bits, indexed by address |
| irq_ovf | output | 1 | Sticky overflow interrupt flag |
| irq_cmp | output | 1 | Sticky compare interrupt flag |
| ev_ovf | output | 1 | Overflow event pulse |
| ev_cmp | output | 1 | Compare event pulse |

## Verification
On every cycle the assertions check the reload to zero after an overflow, that a disabled counter holds its count, that held write data stays frozen while busy, that busy rises after an accepted write, that flags set after each crossed occurrence and stay set until cleared, that events are single-cycle and always accompanied by a flag, and that periods of two or more never drop an event. Only the bench scenarios can show the overflow interval at the ports, the exact event-to-interrupt ratios for periods 0, 1, 2 and 5, the ignored write while busy, the effect of a count load on the time to a compare match, and the absence of compare matches when the compare value lies beyond the period.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned NREG   = 4;
   typedef enum logic [ADDR_W-1:0] {
      A_CTRL  = 3'd0,
      A_PER   = 3'd1,
      A_CMP   = 3'd2,
      A_CNT   = 3'd3,
      A_FLAGS = 3'd4
   } rtc_addr_e;
endpackage

// File: rtl/rtc_sync.sv
`timescale 1ns/1ps
module rtc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/rtc_wr_xfer.sv
`timescale 1ns/1ps
module rtc_wr_xfer #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         pclk,
   input  logic         prst_n,
   input  logic         cclk,
   input  logic         crst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic         busy,
   output logic         ld,
   output logic [W-1:0] ldata
);
   logic         req_t;
   logic [W-1:0] hold;
   logic         ack_s;
   logic         req_s;
   logic         req_d;

   // peripheral side: capture value and flip request when idle
   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         req_t <= 1'b0;
         hold  <= '0;
      end else if (wr && !busy) begin
         req_t <= ~req_t;
         hold  <= wdata;
      end
   end

   assign busy = req_t ^ ack_s;

   rtc_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(cclk), .rst_n(crst_n), .d(req_t), .q(req_s));

   // counter side: detect the request edge, echo it back as acknowledge
   always_ff @(posedge cclk or negedge crst_n) begin
      if (!crst_n) req_d <= 1'b0;
      else         req_d <= req_s;
   end

   assign ld    = req_s ^ req_d;
   assign ldata = hold;

   rtc_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(pclk), .rst_n(prst_n), .d(req_d), .q(ack_s));

   AST_BUSY_ON_WR: assert property (@(posedge pclk) disable iff (!prst_n)
      (wr && !busy) |=> busy);                              // R5
   AST_HOLD_FROZEN: assert property (@(posedge pclk) disable iff (!prst_n)
      busy |=> $stable(hold));                              // R6
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core #(
   parameter int unsigned DW = 16
) (
   input  logic          cclk,
   input  logic          crst_n,
   input  logic [3:0]    ld,
   input  logic          en_d,
   input  logic [DW-1:0] per_d,
   input  logic [DW-1:0] cmp_d,
   input  logic [DW-1:0] cnt_d,
   output logic          ovf_t,
   output logic          cmp_t,
   output logic          ovf_et,
   output logic          cmp_et
);
   logic          en;
   logic [DW-1:0] per;
   logic [DW-1:0] cmpv;
   logic [DW-1:0] cnt;
   logic [1:0]    th_o;
   logic [1:0]    th_c;
   logic          ovf_hit;
   logic          cmp_hit;

   // index of the last occurrence in a thinning group
   function automatic logic [1:0] thin_last(input logic [DW-1:0] p);
      if (p == '0)          return 2'd2;
      else if (p == DW'(1)) return 2'd1;
      else                  return 2'd0;
   endfunction

   assign ovf_hit = en && !ld[3] && (cnt == per);
   assign cmp_hit = en && !ld[3] && (cnt == cmpv);

   always_ff @(posedge cclk or negedge crst_n) begin
      if (!crst_n) begin
         en     <= 1'b0;
         per    <= '0;
         cmpv   <= '0;
         cnt    <= '0;
         ovf_t  <= 1'b0;
         cmp_t  <= 1'b0;
         ovf_et <= 1'b0;
         cmp_et <= 1'b0;
         th_o   <= '0;
         th_c   <= '0;
      end else begin
         if (ld[0]) en   <= en_d;
         if (ld[1]) per  <= per_d;
         if (ld[2]) cmpv <= cmp_d;

         if (ld[3])   cnt <= cnt_d;
         else if (en) cnt <= (cnt == per) ? '0 : cnt + DW'(1);

         if (ovf_hit) ovf_t <= ~ovf_t;
         if (cmp_hit) cmp_t <= ~cmp_t;

         if (ovf_hit) begin
            if (th_o >= thin_last(per)) begin
               th_o   <= '0;
               ovf_et <= ~ovf_et;
            end else begin
               th_o <= th_o + 2'd1;
            end
         end
         if (cmp_hit) begin
            if (th_c >= thin_last(per)) begin
               th_c   <= '0;
               cmp_et <= ~cmp_et;
            end else begin
               th_c <= th_c + 2'd1;
            end
         end
         if (ld[1]) begin
            th_o <= '0;
            th_c <= '0;
         end
      end
   end

   AST_OVF_RELOAD: assert property (@(posedge cclk) disable iff (!crst_n)
      ovf_hit |=> (cnt == '0));                                        // R2
   AST_IDLE_HOLD: assert property (@(posedge cclk) disable iff (!crst_n)
      (!en && !ld[3]) |=> $stable(cnt));                               // R2
   AST_FULL_RATE_OVF: assert property (@(posedge cclk) disable iff (!crst_n)
      (ovf_hit && per >= DW'(2)) |=> (ovf_et != $past(ovf_et)));       // R9
   AST_FULL_RATE_CMP: assert property (@(posedge cclk) disable iff (!crst_n)
      (cmp_hit && per >= DW'(2)) |=> (cmp_et != $past(cmp_et)));       // R9
endmodule

// File: rtl/rtc_evt_sync.sv
`timescale 1ns/1ps
module rtc_evt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl,
   output logic pulse
);
   logic s;
   logic prev;

   rtc_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(tgl), .q(s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= s;
   end

   assign pulse = s ^ prev;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);                                    // R8
endmodule

// File: rtl/rtc_async_counter.sv
`timescale 1ns/1ps
module rtc_async_counter
   import rtc_pkg::*;
#(
   parameter int unsigned DW     = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic              pclk,
   input  logic              prst_n,
   input  logic              cclk,
   input  logic              crst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic [NREG-1:0]   busy,
   output logic              irq_ovf,
   output logic              irq_cmp,
   output logic              ev_ovf,
   output logic              ev_cmp
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("rtc_async_counter: DW must be at least 2");
      end
      if ((1 << ADDR_W) < NREG + 1) begin : g_bad_aw
         $error("rtc_async_counter: address space too small");
      end
   endgenerate

   logic [NREG-1:0] ld;
   logic            en_d;
   logic [DW-1:0]   ldat [1:NREG-1];

   // one handshake per register; the control register carries only enable
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_ctrl
         logic q;
         rtc_wr_xfer #(.W(1), .STAGES(STAGES)) u_xfer (
            .pclk(pclk), .prst_n(prst_n), .cclk(cclk), .crst_n(crst_n),
            .wr(wr_en && (wr_addr == ADDR_W'(i))), .wdata(wr_data[0]),
            .busy(busy[i]), .ld(ld[i]), .ldata(q));
         assign en_d = q;
      end else begin : g_word
         rtc_wr_xfer #(.W(DW), .STAGES(STAGES)) u_xfer (
            .pclk(pclk), .prst_n(prst_n), .cclk(cclk), .crst_n(crst_n),
            .wr(wr_en && (wr_addr == ADDR_W'(i))), .wdata(wr_data),
            .busy(busy[i]), .ld(ld[i]), .ldata(ldat[i]));
      end
   end

   logic ovf_t, cmp_t, ovf_et, cmp_et;

   rtc_core #(.DW(DW)) u_core (
      .cclk(cclk), .crst_n(crst_n), .ld(ld), .en_d(en_d),
      .per_d(ldat[1]), .cmp_d(ldat[2]), .cnt_d(ldat[3]),
      .ovf_t(ovf_t), .cmp_t(cmp_t), .ovf_et(ovf_et), .cmp_et(cmp_et));

   logic ovf_p, cmp_p;

   rtc_evt_sync #(.STAGES(STAGES)) u_ovf_irq (
      .clk(pclk), .rst_n(prst_n), .tgl(ovf_t),  .pulse(ovf_p));
   rtc_evt_sync #(.STAGES(STAGES)) u_cmp_irq (
      .clk(pclk), .rst_n(prst_n), .tgl(cmp_t),  .pulse(cmp_p));
   rtc_evt_sync #(.STAGES(STAGES)) u_ovf_ev (
      .clk(pclk), .rst_n(prst_n), .tgl(ovf_et), .pulse(ev_ovf));
   rtc_evt_sync #(.STAGES(STAGES)) u_cmp_ev (
      .clk(pclk), .rst_n(prst_n), .tgl(cmp_et), .pulse(ev_cmp));

   logic [1:0] clr;
   assign clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[1:0] : 2'b00;

   // a new occurrence wins over a clear in the same cycle
   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         irq_ovf <= 1'b0;
         irq_cmp <= 1'b0;
      end else begin
         irq_ovf <= ovf_p | (irq_ovf & ~clr[0]);
         irq_cmp <= cmp_p | (irq_cmp & ~clr[1]);
      end
   end

   AST_OVF_FLAG_SET: assert property (@(posedge pclk) disable iff (!prst_n)
      ovf_p |=> irq_ovf);                                   // R3
   AST_OVF_FLAG_STICKY: assert property (@(posedge pclk) disable iff (!prst_n)
      (irq_ovf && !clr[0]) |=> irq_ovf);                    // R3
   AST_CMP_FLAG_SET: assert property (@(posedge pclk) disable iff (!prst_n)
      cmp_p |=> irq_cmp);                                   // R4
   AST_CMP_FLAG_STICKY: assert property (@(posedge pclk) disable iff (!prst_n)
      (irq_cmp && !clr[1]) |=> irq_cmp);                    // R4
   AST_EV_OVF_WITH_IRQ: assert property (@(posedge pclk) disable iff (!prst_n)
      ev_ovf |=> irq_ovf);                                  // R8
   AST_EV_CMP_WITH_IRQ: assert property (@(posedge pclk) disable iff (!prst_n)
      ev_cmp |=> irq_cmp);                                  // R8
endmodule

// File: tb/rtc_async_counter_tb.sv
`timescale 1ns/1ps
module rtc_async_counter_tb;
   localparam real CPER = 37.0;

   logic        pclk = 1'b0, cclk = 1'b0;
   logic        prst_n = 1'b0, crst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  busy;
   logic        irq_ovf, irq_cmp, ev_ovf, ev_cmp;

   int tests = 0, fails = 0, cyc = 0;
   int n_ovf, n_cmp, e_ovf, e_cmp, pulse_err, seq_err;
   realtime t_first, t_last;

   rtc_async_counter u_dut (
      .pclk(pclk), .prst_n(prst_n), .cclk(cclk), .crst_n(crst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
      .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .ev_ovf(ev_ovf), .ev_cmp(ev_cmp));

   always #4 pclk = ~pclk;
   initial begin
      #3;
      forever #(CPER/2.0) cclk = ~cclk;
   end

   always @(posedge pclk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   function automatic int thin_mod(input int p);
      if (p == 0) return 3;
      if (p == 1) return 2;
      return 1;
   endfunction

   function automatic int absd(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge pclk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge pclk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy != 4'b0 && n < 300) begin
         @(negedge pclk);
         n++;
      end
      chk(busy == 4'b0, "R5", "busy clears", int'(busy), 0);
      repeat (12) @(negedge pclk);
   endtask

   // observe outputs, clear flags as they appear, optionally disable at ctl_at
   task automatic measure(input int ncyc, input int ctl_at);
      logic pe_o = 1'b0, pe_c = 1'b0;
      n_ovf = 0; n_cmp = 0; e_ovf = 0; e_cmp = 0; pulse_err = 0; seq_err = 0;
      for (int k = 0; k < ncyc; k++) begin
         @(negedge pclk);
         if (ev_ovf) begin e_ovf++; if (pe_o) pulse_err++; end
         if (ev_cmp) begin e_cmp++; if (pe_c) pulse_err++; end
         if (pe_o && !irq_ovf) seq_err++;
         if (pe_c && !irq_cmp) seq_err++;
         pe_o = ev_ovf; pe_c = ev_cmp;
         wr_en = 1'b0;
         if (k == ctl_at) begin
            wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'd0;
         end else if (irq_ovf || irq_cmp) begin
            if (irq_ovf) begin
               n_ovf++;
               if (n_ovf == 1) t_first = $realtime;
               t_last = $realtime;
            end
            if (irq_cmp) n_cmp++;
            wr_en = 1'b1; wr_addr = 3'd4; wr_data = {14'd0, irq_cmp, irq_ovf};
         end
      end
      @(negedge pclk);
      wr_en = 1'b0;
   endtask

   task automatic setup(input int p, input int c);
      wr(3'd0, 16'd0);
      wait_idle();
      wr(3'd1, 16'(p));
      wr(3'd2, 16'(c));
      wr(3'd3, 16'd0);
      wait_idle();
   endtask

   task automatic run_check(input int p, input int c, input bit cmp_in_range);
      int   ctl_at = 700;
      int   exp_ovf;
      real  span, exp_span;
      wr(3'd4, 16'd3);
      wr(3'd0, 16'd1);
      measure(ctl_at + 120, ctl_at);
      exp_ovf = int'((ctl_at * 8.0) / (CPER * (p + 1)));
      chk(absd(n_ovf, exp_ovf) <= 3, "R2", $sformatf("ovf count p=%0d", p), n_ovf, exp_ovf);
      if (n_ovf >= 3) begin
         span = t_last - t_first;
         exp_span = (n_ovf - 1) * (p + 1) * CPER;
         chk((span - exp_span) < 20.0 && (exp_span - span) < 20.0, "R2",
             $sformatf("ovf interval p=%0d", p), int'(span), int'(exp_span));
      end
      chk(e_ovf == n_ovf / thin_mod(p), "R9", $sformatf("ovf events p=%0d", p),
          e_ovf, n_ovf / thin_mod(p));
      if (cmp_in_range) begin
         chk(absd(n_cmp, n_ovf) <= 1, "R4", $sformatf("cmp count p=%0d c=%0d", p, c),
             n_cmp, n_ovf);
         chk(e_cmp == n_cmp / thin_mod(p), "R9", $sformatf("cmp events p=%0d", p),
             e_cmp, n_cmp / thin_mod(p));
      end else begin
         chk(n_cmp == 0, "R4", "no cmp beyond period", n_cmp, 0);
      end
      chk(pulse_err == 0, "R8", "event pulse width", pulse_err, 0);
      chk(seq_err == 0, "R8", "flag after event", seq_err, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge pclk);
      prst_n = 1'b1; crst_n = 1'b1;
      repeat (3) @(negedge pclk);

      // R1: reset state
      chk(busy == 4'b0 && !irq_ovf && !irq_cmp && !ev_ovf && !ev_cmp, "R1",
          "outputs after reset", {busy, irq_ovf, irq_cmp, ev_ovf, ev_cmp}, 0);
      // R1: counter at zero with zero period overflows immediately when enabled
      wr(3'd0, 16'd1);
      measure(60, 50);
      chk(n_ovf > 0, "R1", "zero period overflows from reset", n_ovf, 1);

      // directed period values 0, 1, 2, 5 (R9)
      setup(0, 0); run_check(0, 0, 1'b1);
      setup(1, 1); run_check(1, 1, 1'b1);
      setup(2, 1); run_check(2, 1, 1'b1);
      setup(5, 3); run_check(5, 3, 1'b1);

      // R4: compare beyond period never matches
      setup(5, 9); run_check(5, 9, 1'b0);

      // R5/R6: second write while busy is ignored
      wr(3'd0, 16'd0);
      wait_idle();
      wr(3'd1, 16'd4);
      chk(busy[1] == 1'b1, "R5", "busy after period write", int'(busy[1]), 1);
      wr(3'd1, 16'd9);
      wait_idle();
      wr(3'd2, 16'd0);
      wr(3'd3, 16'd0);
      wait_idle();
      run_check(4, 0, 1'b1);   // R6: period 4 in force, not 9

      // R2: disabled counter raises nothing
      wr(3'd4, 16'd3);
      measure(300, -1);
      chk(n_ovf == 0 && n_cmp == 0, "R2", "no flags while disabled", n_ovf + n_cmp, 0);

      // R7: count load shortens time to compare; R3/R4 sticky and selective clear
      begin
         realtime t0, dt;
         int n = 0;
         setup(1000, 900);
         wr(3'd3, 16'd895);
         wait_idle();
         wr(3'd4, 16'd3);
         t0 = $realtime;
         wr(3'd0, 16'd1);
         while (!irq_cmp && n < 80) begin @(negedge pclk); n++; end
         dt = $realtime - t0;
         chk(dt >= 5 * CPER && dt <= 12 * CPER, "R7", "time to cmp after count load",
             int'(dt), int'(9 * CPER));
         chk(!irq_ovf, "R7", "no overflow after count load", int'(irq_ovf), 0);
         repeat (20) @(negedge pclk);
         chk(irq_cmp, "R3", "cmp flag sticky", int'(irq_cmp), 1);
         wr(3'd4, 16'd1);
         chk(irq_cmp, "R3", "clearing ovf bit keeps cmp flag", int'(irq_cmp), 1);
         wr(3'd4, 16'd2);
         chk(!irq_cmp, "R4", "cmp flag cleared by bit 1", int'(irq_cmp), 0);
      end

      // constrained random periods 2..15 with compare inside period
      for (int it = 0; it < 6; it++) begin
         int p = 2 + int'($urandom % 14);
         int c = int'($urandom % (p + 1));
         setup(p, c);
         run_check(p, c, 1'b1);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule